// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single register transactions against an Ethernet PHY over the two-wire management bus. The bus is a management clock that the block drives and a shared data line that the block drives through an output and an output enable and reads back through an input. The host presents a PHY address, a register address, write data and a read/write select, then pulses a request. The block drives a preamble of ones and the command bits. For a read, it releases the line, checks that the PHY pulled the line low in the turnaround slot, shifts in sixteen data bits, and releases the line again with one more clock. For a write, it sends the whole 32-bit command word and then releases the line with one clock.

The management clock is made from the system clock. Each half period lasts `HALF_CLKS` system clocks. The host sees `busy` for the whole transaction and a one-cycle `done` pulse at the end. For a read, the result is on `rd_data` in the cycle of `done`. If the PHY did not answer in the turnaround slot, the result is all ones.

Top module: `mdio_master`

## Requirements
- R1: Every transaction starts with 32 management clock periods in which the data line is driven to 1 with the output enable on.
- R2: A write then drives 32 command bits, most significant first: `01` (start), `01` (write opcode), PHY address at bits 27:23, register address at bits 22:18, `10` (turnaround), 16 data bits. One further clock period follows with the output enable off, giving 65 rising clock edges in total.
- R3: A read then drives 14 bits, most significant first: `01`, `10` (read opcode), PHY address, register address. It then keeps the output enable off for the remaining 18 rising edges: one turnaround, 16 data bits and one closing release. This gives 64 rising edges in total.
- R4: Every data bit is set up while the management clock is low and held while it is high. Each half period lasts `HALF_CLKS` system clocks. A driven run ends with one extra low half period before the line is released. As a result, `busy` lasts 132·`HALF_CLKS` cycles for a write and 130·`HALF_CLKS` cycles for a read.
- R5: A read captures 16 data bits, most significant first. Each bit is sampled from `mdio_in` at the end of the high half period of its clock.
- R6: On a read, `mdio_in` is sampled at the end of the high half of the turnaround clock. If it is 1, the PHY did not acknowledge, and `rd_data` is forced to 16'hFFFF.
- R7: `busy` rises in the cycle after a request is accepted. `done` is a single-cycle pulse in the first cycle with `busy` low after a transaction, and a read result is valid in that cycle.
- R8: A request raised while `busy` is high is ignored: the frame in progress and its length are unchanged, and no second frame follows.
- R9: Reset clears `rd_data` to zero. `rd_data` changes only on the `done` of a read, so writes leave it unchanged.
- R10: While idle, `mdc` is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a transaction (taken only when idle) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input |

## Verification
Writes are tried with all-zero and all-one address and data fields, which separate a field placed at the wrong bit from a field that is dropped. Reads are tried with an acknowledging PHY returning 16'h0000, 16'hFFFF and asymmetric words such as 16'h8001 and 16'hA5C3; these reveal bit-order and sampling-slot errors that a symmetric word would hide. A read from a PHY that leaves the line high in the turnaround must yield all ones, even though the data bits it then returns are not all ones. Randomly chosen reads and writes are interleaved, with requests injected mid-frame, and the bench confirms that `rd_data` survives the writes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_AW   = 5;
    localparam int REG_AW   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_LEN  = 32;
    localparam int WORD_W   = 2 + 2 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int RD_BITS  = WORD_W - 2 - DATA_W;
    localparam int CNT_W    = $clog2(WORD_W);

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] TURN_CODE  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_PRE_END,
        ST_CMD,
        ST_CMD_END,
        ST_REL,
        ST_DATA,
        ST_REL_END
    } mdio_st_e;

    typedef struct packed {
        logic              rd;
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    function automatic logic [WORD_W-1:0] frame_word(input mdio_req_t r);
        return {START_CODE, (r.rd ? OP_READ : OP_WRITE), r.phy, r.regad,
                TURN_CODE, r.wdata};
    endfunction

    function automatic logic state_has_high(input mdio_st_e s);
        return (s == ST_PRE) || (s == ST_CMD) || (s == ST_REL) ||
               (s == ST_DATA) || (s == ST_REL_END);
    endfunction

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_CLKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mdio_req_t req_in,
    input  logic      tick,
    output logic      busy,
    output logic      done,
    output logic      mdc,
    output logic      mdo,
    output logic      oe,
    output logic      smp_data,
    output logic      smp_ack,
    output logic      fin_rd
);
    mdio_st_e          st;
    logic              ph;
    logic [CNT_W-1:0]  bitn;
    logic [WORD_W-1:0] tx;
    logic              rd_q;
    logic              done_q;
    logic              end_half;

    assign end_half = tick && (ph || !state_has_high(st));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            ph     <= 1'b0;
            bitn   <= '0;
            tx     <= '0;
            rd_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && st == ST_IDLE) begin
                st   <= ST_PRE;
                ph   <= 1'b0;
                bitn <= CNT_W'(PRE_LEN - 1);
                tx   <= frame_word(req_in);
                rd_q <= req_in.rd;
            end else if (st != ST_IDLE && tick) begin
                if (state_has_high(st) && !ph) begin
                    ph <= 1'b1;
                end else begin
                    ph <= 1'b0;
                    unique case (st)
                        ST_PRE: begin
                            if (bitn == '0) st <= ST_PRE_END;
                            else bitn <= bitn - 1'b1;
                        end
                        ST_PRE_END: begin
                            st   <= ST_CMD;
                            bitn <= rd_q ? CNT_W'(RD_BITS - 1) : CNT_W'(WORD_W - 1);
                        end
                        ST_CMD: begin
                            if (bitn == '0) begin
                                st <= ST_CMD_END;
                            end else begin
                                bitn <= bitn - 1'b1;
                                tx   <= {tx[WORD_W-2:0], 1'b0};
                            end
                        end
                        ST_CMD_END: st <= ST_REL;
                        ST_REL: begin
                            if (rd_q) begin
                                st   <= ST_DATA;
                                bitn <= CNT_W'(DATA_W - 1);
                            end else begin
                                st     <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                        end
                        ST_DATA: begin
                            if (bitn == '0) st <= ST_REL_END;
                            else bitn <= bitn - 1'b1;
                        end
                        ST_REL_END: begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign busy     = (st != ST_IDLE);
    assign done     = done_q;
    assign mdc      = ph;
    assign oe       = (st == ST_PRE) || (st == ST_PRE_END) ||
                      (st == ST_CMD) || (st == ST_CMD_END);
    assign mdo      = ((st == ST_PRE) || (st == ST_PRE_END)) ? 1'b1 :
                      ((st == ST_CMD) || (st == ST_CMD_END)) ? tx[WORD_W-1] : 1'b0;
    assign smp_data = end_half && ph && (st == ST_DATA);
    assign smp_ack  = end_half && ph && (st == ST_REL) && rd_q;
    assign fin_rd   = end_half && (st == ST_REL_END);
endmodule

// File: rtl/mdio_rd_capture.sv
module mdio_rd_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_data,
    input  logic              smp_ack,
    input  logic              fin_rd,
    input  logic              din,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] sh;
    logic              ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            ack_q   <= 1'b0;
            rd_data <= '0;
        end else begin
            if (smp_ack)  ack_q <= !din;
            if (smp_data) sh    <= {sh[DATA_W-2:0], din};
            if (fin_rd)   rd_data <= ack_q ? sh : '1;
        end
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_rd,
    input  logic [PHY_AW-1:0] req_phy,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    mdio_req_t r_in;
    logic      tick, smp_data, smp_ack, fin_rd;

    assign r_in = '{rd: req_rd, phy: req_phy, regad: req_reg, wdata: req_wdata};

    mdio_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (req),
        .req_in   (r_in),
        .tick     (tick),
        .busy     (busy),
        .done     (done),
        .mdc      (mdc),
        .mdo      (mdio_out),
        .oe       (mdio_oe),
        .smp_data (smp_data),
        .smp_ack  (smp_ack),
        .fin_rd   (fin_rd)
    );

    mdio_rd_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .smp_data (smp_data),
        .smp_ack  (smp_ack),
        .fin_rd   (fin_rd),
        .din      (mdio_in),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int HALF_CLKS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdio_oe,
    input logic [15:0] rd_data
);
    logic [15:0] hold;
    logic        last_mdc;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            last_mdc <= 1'b0;
        end else begin
            last_mdc <= mdc;
            if (mdc != last_mdc)   hold <= 16'd1;
            else if (hold != '1)   hold <= hold + 16'd1;
        end
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R8
    start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_data));

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (rst)
        (last_mdc && !mdc) |-> (hold == 16'(HALF_CLKS)));
endmodule

bind mdio_master mdio_master_chk #(.HALF_CLKS(HALF_CLKS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_oe (mdio_oe),
    .rd_data (rd_data)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_rd = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_in = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_rd = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_master #(.HALF_CLKS(HALF)) uut (
        .clk(clk), .rst(rst), .req(req), .req_rd(req_rd), .req_phy(req_phy),
        .req_reg(req_reg), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .mdio_in(mdio_in)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cmd_word(input bit rd, input logic [4:0] phy,
                                             input logic [4:0] ra, input logic [15:0] wd);
        return {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
    endfunction

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wd, input bit ack, input logic [15:0] pd,
                             input bit poke);
        logic [31:0] word;
        int nbits, tot, busy_exp, nbusy, edges, bad_pre, bad_cmd, bad_rel;
        bit prev, fin, exp_mdo;
        word     = cmd_word(rd, phy, ra, wd);
        nbits    = rd ? 14 : 32;
        tot      = rd ? 64 : 65;
        busy_exp = (rd ? 130 : 132) * HALF;
        @(negedge clk);
        req = 1'b1; req_rd = rd; req_phy = phy; req_reg = ra; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        // R7: busy rises the cycle after the request
        check(busy === 1'b1, "R7 busy after request", 32'(busy), 32'd1);
        nbusy = 1; edges = 0; bad_pre = 0; bad_cmd = 0; bad_rel = 0;
        prev = 1'b0; fin = 1'b0; mdio_in = 1'b1;
        for (int k = 0; k < 20000 && !fin; k++) begin
            @(negedge clk);
            if (poke && k == 20) begin
                req = 1'b1; req_rd = ~rd; req_phy = ~phy; req_reg = ~ra; req_wdata = ~wd;
            end
            if (poke && k == 21) req = 1'b0;
            if (mdc && !prev) begin
                edges++;
                if (edges <= 32) begin
                    if (mdio_oe !== 1'b1 || mdio_out !== 1'b1) bad_pre++;
                end else if (edges <= 32 + nbits) begin
                    exp_mdo = word[31-(edges-33)];
                    if (mdio_oe !== 1'b1 || mdio_out !== exp_mdo) bad_cmd++;
                end else begin
                    if (mdio_oe !== 1'b0) bad_rel++;
                end
                if (rd) begin
                    if (edges == 47) mdio_in = ack ? 1'b0 : 1'b1;
                    else if (edges >= 48 && edges <= 63) mdio_in = pd[15-(edges-48)];
                    else if (edges == 64) mdio_in = 1'b1;
                end
            end
            prev = mdc;
            if (busy) nbusy++;
            if (done) fin = 1'b1;
        end
        check(fin, "R7 done seen", 32'(fin), 32'd1);
        // R1
        check(bad_pre == 0, "R1 preamble bits", 32'(bad_pre), 32'd0);
        if (rd) begin
            // R3
            check(bad_cmd == 0, "R3 read command bits", 32'(bad_cmd), 32'd0);
            check(bad_rel == 0, "R3 line released", 32'(bad_rel), 32'd0);
            exp_rd = ack ? pd : 16'hFFFF;
            // R5 R6
            check(rd_data === exp_rd, ack ? "R5 read data" : "R6 no ack all ones",
                  32'(rd_data), 32'(exp_rd));
        end else begin
            // R2
            check(bad_cmd == 0 && bad_rel == 0, "R2 write frame bits",
                  32'(bad_cmd + bad_rel), 32'd0);
            // R9
            check(rd_data === exp_rd, "R9 rd_data kept over write",
                  32'(rd_data), 32'(exp_rd));
        end
        // R4
        check(edges == tot, "R4 clock edge count", 32'(edges), 32'(tot));
        check(nbusy == busy_exp, "R4 busy length", 32'(nbusy), 32'(busy_exp));
        // R10
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R10 idle after frame",
              {30'd0, mdc, mdio_oe}, 32'd0);
        @(negedge clk);
        // R7
        check(done === 1'b0, "R7 done single cycle", 32'(done), 32'd0);
        if (poke) begin
            // R8: the injected request must not start another frame
            check(busy === 1'b0 && bad_cmd == 0 && nbusy == busy_exp,
                  "R8 request during busy ignored", 32'(busy), 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 R10: reset state
        check(busy === 1'b0 && done === 1'b0, "R10 reset idle",
              {30'd0, busy, done}, 32'd0);
        check(mdc === 1'b0 && mdio_oe === 1'b0, "R10 reset lines quiet",
              {30'd0, mdc, mdio_oe}, 32'd0);
        check(rd_data === 16'h0000, "R9 reset rd_data", 32'(rd_data), 32'd0);

        run_frame(1'b0, 5'd0,  5'd0,  16'h0000, 1'b1, 16'h0000, 1'b0);
        run_frame(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b1, 16'h0000, 1'b1);
        run_frame(1'b1, 5'd1,  5'd2,  16'h0000, 1'b1, 16'hA5C3, 1'b0);
        run_frame(1'b0, 5'd9,  5'd17, 16'h1234, 1'b1, 16'h0000, 1'b0);
        run_frame(1'b1, 5'd3,  5'd4,  16'h0000, 1'b0, 16'h1234, 1'b0);
        run_frame(1'b1, 5'd31, 5'd0,  16'h0000, 1'b1, 16'h0000, 1'b1);
        run_frame(1'b1, 5'd0,  5'd31, 16'h0000, 1'b1, 16'hFFFF, 1'b0);
        run_frame(1'b1, 5'd21, 5'd10, 16'h0000, 1'b1, 16'h8001, 1'b0);

        for (int i = 0; i < 20; i++) begin
            logic [31:0] r;
            r = $urandom();
            run_frame(r[0], 5'($urandom()), 5'($urandom()), 16'($urandom()),
                      (r[3:1] != 3'd0), 16'($urandom()), r[4]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule